// File: doc/BRIEF.md
# Page-Mode Byte-Load Write Engine

This block is the device-side write engine of a byte-wide page-mode nonvolatile memory model. A host issues write cycles through active-low chip select, write enable and output enable pins. The first accepted write opens a page window and fixes the page address. Later writes to the same page go into a page buffer, and each one restarts an inactivity timer. When the timer runs out, the engine enters an internal programming phase of fixed length. During that phase the buffered bytes are copied into the memory array, and only the bytes that were actually loaded are written.

While programming is under way, every read returns a status byte instead of array data. Bit 7 is the inverse of bit 7 of the last byte accepted, so a host polling the written location sees the wrong value until the write finishes. Bit 6 flips on each successive read, so back-to-back reads differ while the engine is busy. Bits 5:0 echo the last accepted byte. When programming ends, reads return array data again. Both time windows are parameters counted in clock cycles, which lets simulation use short values.

The engine has three states. `ST_IDLE` waits for a write. The transition "open" goes from `ST_IDLE` to `ST_LOAD` on the first accepted write. `ST_LOAD` holds the window open. Its transition "reload" stays in `ST_LOAD` on each same-page write and restarts the timer. Its transition "close" goes from `ST_LOAD` to `ST_PROG` when the timer expires. `ST_PROG` is the programming phase. Its transition "finish" goes from `ST_PROG` back to `ST_IDLE` when the programming timer expires.

Top module: `eepw_page_engine`

## Requirements
- R1: After reset the engine is in `ST_IDLE`, `rd_valid` is 0 and `rdata` is 0x00.
- R2: A write is taken only on the first clock edge at which `cs_n`=0, `we_n`=0 and `oe_n`=1 all hold, and `addr` and `wdata` are sampled on that edge. A strobe with `oe_n`=0 or with `cs_n`=1 loads nothing.
- R3: In `ST_IDLE`, a write opens a page window. The page number is `addr[ADDR_W-1:7]` and the byte offset within the page is `addr[6:0]`, so a page holds 128 bytes.
- R4: During an open window, a write whose page number differs from the latched page is dropped. It changes no byte and does not restart the timer.
- R5: Every accepted write reloads a timeout of `BLC_CYC` clocks. A read sampled on the `BLC_CYC`-th edge after the last accepted write still returns array data. The engine is in `ST_PROG` from that edge on.
- R6: `ST_PROG` lasts exactly `PROG_CYC` clocks, and writes made during it are ignored. A read on the last edge of `ST_PROG` returns status, and a read on the edge after it returns data.
- R7: At programming, each offset loaded in the window is written to the array at {page, offset}. If an offset was loaded more than once, the last value wins. Offsets that were not loaded keep their previous array contents.
- R8: A read while busy returns bit 7 equal to the inverse of bit 7 of the last accepted byte.
- R9: While busy, status bit 6 is 0 on the first read of a programming phase and then flips on every later read. Status bits 5:0 equal those bits of the last accepted byte.
- R10: A read that is not busy returns the array byte at `addr`. A read during the window returns the old array contents, not the buffered bytes.
- R11: A read is taken on the first edge at which `cs_n`=0, `oe_n`=0 and `we_n`=1 hold. It yields exactly one `rd_valid` pulse, one clock later, with `rdata` valid alongside it, however long the strobe is held.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cs_n | input | 1 | Chip select, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | ADDR_W | Byte address: page number above bit 6, offset in bits 6:0 |
| wdata | input | 8 | Write data byte |
| rdata | output | 8 | Read result: array data or busy status |
| rd_valid | output | 1 | One-clock pulse marking a new read result |

## Verification
The engine is driven with several write patterns, and each one separates a different kind of fault:
- A full sequential page fill shows whether each load reaches its own offset.
- A sparse window with a repeated offset, a foreign-page write and malformed strobes shows the partial-commit and drop rules apart from the normal path.
- A stream of foreign-page writes placed right after one good load exposes a timer that restarts when it should not.
- Reads placed on the exact edges around both timer expiries pin down the window length and the programming length to the cycle.
- Repeated status reads, plus one long held read, show the toggle sequence and the one-result-per-strobe rule.

// File: rtl/eepw_pkg.sv
`timescale 1ns/1ps
package eepw_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LOAD = 2'd1,
        ST_PROG = 2'd2
    } pw_state_t;

    // Status byte seen by a read while programming is in progress
    function automatic logic [7:0] busy_status(input logic [7:0] last_byte, input logic tog);
        return {~last_byte[7], tog, last_byte[5:0]};
    endfunction

endpackage

// File: rtl/eepw_strobe.sv
`timescale 1ns/1ps
module eepw_strobe (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic we_n,
    input  logic oe_n,
    output logic wr_start,
    output logic rd_start
);
    logic wr_act, rd_act;
    logic wr_q, rd_q;

    assign wr_act = !cs_n && !we_n &&  oe_n;
    assign rd_act = !cs_n &&  we_n && !oe_n;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_q <= 1'b0;
            rd_q <= 1'b0;
        end else begin
            wr_q <= wr_act;
            rd_q <= rd_act;
        end
    end

    assign wr_start = wr_act && !wr_q;
    assign rd_start = rd_act && !rd_q;

    // R2: a held strobe gives one start only
    a_r2_single_write_start: assert property (@(posedge clk) disable iff (!rst_n)
        wr_start |=> !wr_start);
    // R11: a held read gives one start only
    a_r11_single_read_start: assert property (@(posedge clk) disable iff (!rst_n)
        rd_start |=> !rd_start);

endmodule

// File: rtl/eepw_timer.sv
`timescale 1ns/1ps
module eepw_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expire
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (cnt != '0)
            cnt <= cnt - W'(1);
    end

    assign expire = (cnt == W'(1));

    // R5: without a reload the count falls by one each clock
    a_r5_count_down: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && cnt != '0) |=> (cnt == $past(cnt) - W'(1)));

endmodule

// File: rtl/eepw_page_buf.sv
`timescale 1ns/1ps
module eepw_page_buf #(
    parameter int OFS_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             wr,
    input  logic [OFS_W-1:0] wr_ofs,
    input  logic [7:0]       wr_data,
    input  logic [OFS_W-1:0] rd_ofs,
    output logic [7:0]       rd_data,
    output logic             rd_hit
);
    localparam int PAGE_BYTES = 1 << OFS_W;

    logic [7:0]            bytes_q [PAGE_BYTES];
    logic [PAGE_BYTES-1:0] mask_q;

    always_ff @(posedge clk) begin
        if (wr)
            bytes_q[wr_ofs] <= wr_data;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            mask_q <= '0;
        else if (clr)
            mask_q <= wr ? (PAGE_BYTES'(1) << wr_ofs) : '0;
        else if (wr)
            mask_q[wr_ofs] <= 1'b1;
    end

    assign rd_data = bytes_q[rd_ofs];
    assign rd_hit  = mask_q[rd_ofs];

    // R7: a loaded offset is remembered as loaded
    a_r7_mask_set: assert property (@(posedge clk) disable iff (!rst_n)
        wr |=> mask_q[$past(wr_ofs)]);

endmodule

// File: rtl/eepw_array.sv
`timescale 1ns/1ps
module eepw_array #(
    parameter int AW = 10
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [7:0]    wdata,
    input  logic [AW-1:0] raddr,
    output logic [7:0]    rdata
);
    localparam int DEPTH = 1 << AW;

    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we)
            mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];

endmodule

// File: rtl/eepw_page_engine.sv
`timescale 1ns/1ps
module eepw_page_engine
    import eepw_pkg::*;
#(
    parameter int ADDR_W     = 10,
    parameter int PAGE_OFS_W = 7,
    parameter int BLC_CYC    = 30000,
    parameter int PROG_CYC   = 2000000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wdata,
    output logic [7:0]        rdata,
    output logic              rd_valid
);
    localparam int PAGE_W  = ADDR_W - PAGE_OFS_W;
    localparam int TMR_MAX = (BLC_CYC > PROG_CYC) ? BLC_CYC : PROG_CYC;
    localparam int TMR_W   = $clog2(TMR_MAX + 1);

    pw_state_t state_q, state_d;

    logic                  wr_start, rd_start;
    logic                  tmr_load, tmr_expire;
    logic [TMR_W-1:0]      tmr_val;
    logic [PAGE_W-1:0]     page_q, wr_page;
    logic [PAGE_OFS_W-1:0] wr_ofs;
    logic [7:0]            last_q;
    logic                  tog_q;
    logic [PAGE_OFS_W:0]   cmt_idx;
    logic                  accept, same_load, enter_prog;
    logic [7:0]            buf_byte, arr_rdata;
    logic                  buf_hit, arr_we;
    logic [7:0]            rdata_q;
    logic                  rd_valid_q;

    eepw_strobe u_strobe (
        .clk      (clk),
        .rst_n    (rst_n),
        .cs_n     (cs_n),
        .we_n     (we_n),
        .oe_n     (oe_n),
        .wr_start (wr_start),
        .rd_start (rd_start)
    );

    assign wr_page   = addr[ADDR_W-1:PAGE_OFS_W];
    assign wr_ofs    = addr[PAGE_OFS_W-1:0];
    assign same_load = wr_start && (state_q == ST_LOAD) && (wr_page == page_q);
    assign accept    = (wr_start && (state_q == ST_IDLE)) || same_load;

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (wr_start)                  state_d = ST_LOAD;  // open
            ST_LOAD: if (!same_load && tmr_expire)  state_d = ST_PROG;  // close (reload stays)
            ST_PROG: if (tmr_expire)                state_d = ST_IDLE;  // finish
            default:                                state_d = ST_IDLE;
        endcase
    end

    assign enter_prog = (state_q == ST_LOAD) && (state_d == ST_PROG);

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    assign tmr_load = accept || enter_prog;
    assign tmr_val  = accept ? TMR_W'(BLC_CYC) : TMR_W'(PROG_CYC);

    eepw_timer #(.W(TMR_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expire   (tmr_expire)
    );

    eepw_page_buf #(.OFS_W(PAGE_OFS_W)) u_buf (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (accept && (state_q == ST_IDLE)),
        .wr      (accept),
        .wr_ofs  (wr_ofs),
        .wr_data (wdata),
        .rd_ofs  (cmt_idx[PAGE_OFS_W-1:0]),
        .rd_data (buf_byte),
        .rd_hit  (buf_hit)
    );

    assign arr_we = (state_q == ST_PROG) && !cmt_idx[PAGE_OFS_W] && buf_hit;

    eepw_array #(.AW(ADDR_W)) u_array (
        .clk   (clk),
        .we    (arr_we),
        .waddr ({page_q, cmt_idx[PAGE_OFS_W-1:0]}),
        .wdata (buf_byte),
        .raddr (addr),
        .rdata (arr_rdata)
    );

    // Output and datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            page_q     <= '0;
            last_q     <= '0;
            tog_q      <= 1'b0;
            cmt_idx    <= {1'b1, {PAGE_OFS_W{1'b0}}};
            rdata_q    <= '0;
            rd_valid_q <= 1'b0;
        end else begin
            if (accept && (state_q == ST_IDLE))
                page_q <= wr_page;
            if (accept)
                last_q <= wdata;
            if (enter_prog)
                cmt_idx <= '0;
            else if ((state_q == ST_PROG) && !cmt_idx[PAGE_OFS_W])
                cmt_idx <= cmt_idx + 1'b1;
            if (enter_prog)
                tog_q <= 1'b0;
            else if (rd_start && (state_q == ST_PROG))
                tog_q <= ~tog_q;
            rd_valid_q <= rd_start;
            if (rd_start)
                rdata_q <= (state_q == ST_PROG) ? busy_status(last_q, tog_q) : arr_rdata;
        end
    end

    assign rdata    = rdata_q;
    assign rd_valid = rd_valid_q;

    // R3: the page stays fixed for the whole window
    a_r3_page_held: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LOAD && $past(state_q) == ST_LOAD) |-> $stable(page_q));
    // R5: expiry without a same-page load closes the window
    a_r5_prog_entry: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LOAD && tmr_expire && !wr_start) |=> (state_q == ST_PROG));
    // R6: nothing loaded changes while programming
    a_r6_prog_freeze: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PROG && $past(state_q) == ST_PROG) |-> ($stable(last_q) && $stable(page_q)));
    // R7: every offset visited before programming ends
    a_r7_commit_done: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PROG && tmr_expire) |-> cmt_idx[PAGE_OFS_W]);
    // R8: busy read shows inverted top bit
    a_r8_status_msb: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_start && state_q == ST_PROG) |=> (rdata_q[7] == ~$past(last_q[7])));
    // R11: one result one clock after the read starts
    a_r11_single_valid: assert property (@(posedge clk) disable iff (!rst_n)
        rd_start |=> (rd_valid_q && !rd_start));

endmodule

// File: tb/sim_eepw_page_engine.sv
`timescale 1ns/1ps
module sim_eepw_page_engine;
    localparam int AW   = 10;
    localparam int BLC  = 40;
    localparam int PROG = 300;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cs_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
    logic [AW-1:0] addr = '0;
    logic [7:0]    wdata = '0;
    logic [7:0]    rdata;
    logic          rd_valid;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    int last_load = 0;
    bit finished = 0;

    logic [7:0] expq[$];
    string      tagq[$];

    logic [7:0]   sh [1024];
    logic [7:0]   pv [128];
    logic [127:0] pm = '0;
    int           pp = 0;
    logic [7:0]   lastb = '0;

    eepw_page_engine #(.ADDR_W(AW), .PAGE_OFS_W(7), .BLC_CYC(BLC), .PROG_CYC(PROG)) u0 (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .we_n(we_n), .oe_n(oe_n),
        .addr(addr), .wdata(wdata), .rdata(rdata), .rd_valid(rd_valid)
    );

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc++;

    function automatic logic [7:0] fpat(input int i);
        return 8'(i * 37 + 5);
    endfunction

    function automatic logic [7:0] st(input logic [7:0] b, input logic t);
        return {~b[7], t, b[5:0]};
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && rd_valid) begin
            if (expq.size() == 0)
                check(0, "R11 unexpected rd_valid", 1, 0);
            else begin
                logic [7:0] e;
                string t;
                e = expq.pop_front();
                t = tagq.pop_front();
                check(rdata === e, t, rdata, e);
            end
        end
    end

    // Write cycle; acc tells the bench model whether it should be taken
    task automatic wr(input int a, input int d, input bit acc);
        cs_n = 0; we_n = 0; oe_n = 1; addr = AW'(a); wdata = 8'(d);
        if (acc) begin
            last_load = cyc + 1;
            pp = a >> 7;
            pv[a & 127] = 8'(d);
            pm[a & 127] = 1'b1;
            lastb = 8'(d);
        end
        @(negedge clk);
        cs_n = 1; we_n = 1;
        @(negedge clk);
    endtask

    task automatic wr_bad(input int a, input int d, input bit csn, input bit oen);
        cs_n = csn; we_n = 0; oe_n = oen; addr = AW'(a); wdata = 8'(d);
        @(negedge clk);
        cs_n = 1; we_n = 1; oe_n = 1;
        @(negedge clk);
    endtask

    task automatic rd(input int a, input logic [7:0] exp, input string tag, input int hold);
        cs_n = 0; oe_n = 0; we_n = 1; addr = AW'(a);
        expq.push_back(exp);
        tagq.push_back(tag);
        repeat (hold) @(negedge clk);
        cs_n = 1; oe_n = 1;
        @(negedge clk);
    endtask

    // Drive so that the strobe is sampled on edge number e
    task automatic wait_edge(input int e);
        while (cyc < e - 1) @(negedge clk);
    endtask

    task automatic commit_model();
        for (int i = 0; i < 128; i++)
            if (pm[i]) sh[pp * 128 + i] = pv[i];
        pm = '0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        int L;
        for (int i = 0; i < 1024; i++) sh[i] = '0;
        repeat (4) @(negedge clk);
        check(rd_valid === 1'b0, "R1 rd_valid after reset", rd_valid, 0);
        check(rdata === 8'h00, "R1 rdata after reset", rdata, 0);
        rst_n = 1;
        @(negedge clk);

        // Full page 0 fill (R3, R5 window kept open by loads)
        for (int i = 0; i < 128; i++) wr(i, fpat(i), 1);
        L = last_load;
        wait_edge(L + BLC + 5);
        rd(3, st(lastb, 1'b0), "R8 busy bit7 first read", 1);
        rd(3, st(lastb, 1'b1), "R9 toggle second read", 1);
        rd(3, st(lastb, 1'b0), "R9 toggle third read", 1);
        wait_edge(L + BLC + PROG + 3);
        commit_model();
        rd(0, sh[0], "R7 page fill byte 0", 1);
        rd(77, sh[77], "R7 page fill byte 77", 1);
        rd(127, sh[127], "R3 page fill byte 127", 1);
        rd(64, sh[64], "R11 long read one result", 5);

        // Single-byte page 1 (R3)
        wr(133, 8'h3C, 1);
        L = last_load;
        wait_edge(L + BLC + PROG + 3);
        commit_model();
        rd(133, 8'h3C, "R3 single load on page 1", 1);

        // Sparse window with drops
        wr(5, 8'hA1, 1);
        rd(5, sh[5], "R10 window read old data", 1);
        wr(133, 8'hEE, 0);
        wr(9, 8'hB2, 1);
        wr_bad(20, 8'h11, 1'b0, 1'b0);
        wr_bad(21, 8'h22, 1'b1, 1'b1);
        wr(5, 8'hC3, 1);
        L = last_load;
        wait_edge(L + BLC + 5);
        rd(5, st(8'hC3, 1'b0), "R8 status after repeat load", 1);
        wr(9, 8'h77, 0);
        wait_edge(L + BLC + PROG + 3);
        commit_model();
        rd(5, 8'hC3, "R7 repeated offset last wins", 1);
        rd(9, 8'hB2, "R6 load during programming ignored", 1);
        rd(20, fpat(20), "R2 write with oe low ignored", 1);
        rd(21, fpat(21), "R2 write with cs high ignored", 1);
        rd(6, fpat(6), "R7 unloaded byte kept", 1);
        rd(133, 8'h3C, "R4 foreign page write dropped", 1);

        // Foreign writes must not restart the timer (R4)
        wr(10, 8'h5A, 1);
        L = last_load;
        while (cyc < L + BLC + 4) wr(138, 8'h99, 0);
        wait_edge(L + BLC + 8);
        rd(10, st(8'h5A, 1'b0), "R4 timer not restarted by foreign page", 1);
        wait_edge(L + BLC + PROG + 3);
        commit_model();
        rd(10, 8'h5A, "R7 single byte committed", 1);

        // Exact window and programming edges (R5, R6)
        wr(11, 8'h12, 1);
        L = last_load;
        wait_edge(L + BLC);
        rd(6, sh[6], "R5 read on expiry edge still data", 1);
        wait_edge(L + BLC + PROG);
        rd(6, st(8'h12, 1'b0), "R6 read on last busy edge", 1);
        wait_edge(L + BLC + PROG + 3);
        commit_model();

        wr(12, 8'h34, 1);
        L = last_load;
        wait_edge(L + BLC + 1);
        rd(6, st(8'h34, 1'b0), "R5 first busy edge gives status", 1);
        wait_edge(L + BLC + PROG + 1);
        commit_model();
        rd(12, 8'h34, "R6 data back after programming", 1);

        // Reload restarts the window (R5)
        wr(13, 8'hAA, 1);
        L = last_load;
        repeat (30) @(negedge clk);
        wr(14, 8'hBB, 1);
        wait_edge(L + BLC + 2);
        rd(6, sh[6], "R5 reload keeps window open", 1);
        wait_edge(last_load + BLC + PROG + 3);
        commit_model();
        rd(14, 8'hBB, "R10 idle read returns array", 1);

        repeat (4) @(negedge clk);
        check(expq.size() == 0, "R11 all reads answered", expq.size(), 0);
        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule